// File: doc/BRIEF.md
# Multi-Chip Asynchronous Memory Bus Cycle Sequencer

This block turns single requests from a processor-side port into timed bus cycles on a bank of asynchronous memory chips. The chips share one set of address lines and one bidirectional data bus. Each request carries a direction, a flat address and, for a write, the data. The upper bits of the flat address pick one chip, and the lower bits address a location inside that chip.

Every cycle follows a fixed order. First a set-up clock places the address, the direction level and any write data on the bus. Then one chip select is held for a parameterised number of clocks. After that the bus lines are released one step at a time, with one clock per step. A read samples the data bus in the last selected clock. A write releases the select first, then its data drive, then the address. A read has no data drive to drop, so it releases the select and then the address.

The request side is a valid/ready port. `req_ready` is high only while the sequencer is idle, and a request moves on the clock edge where both `req_valid` and `req_ready` are high. While a cycle runs, `req_ready` stays low, so the requester has to hold its request or withdraw it. There is no response back-pressure: `rsp_done` is a one-clock pulse, and `rsp_rdata` is valid only while that pulse is high.

Top module: `sram_bus_seq`

## Requirements
- R1: The chip index is the top CHIP_IDX_W bits of `req_addr`, and the offset is the remaining low bits. The offset appears on `mem_addr`, and select bit `mem_cs[index]` is the one asserted.
- R2: `req_ready` is high only in the idle state. A request is accepted only on a clock edge with `req_valid` and `req_ready` both high. A request held on the port while a cycle runs has no effect: no new bus cycle starts from it after the current one ends.
- R3: In the first clock after acceptance, `mem_addr_en` is 1 and `mem_cs` is all zero. `mem_rw` is 0 for a write and 1 for a read. On a write, `mem_data_oe` is 1 and the write data is on `mem_data`.
- R4: At most one bit of `mem_cs` is ever high. For a populated chip, that bit is high for exactly HOLD_CYC consecutive clocks, in clocks 2 through HOLD_CYC+1 after acceptance.
- R5: During a read, `mem_data_oe` stays 0 for the whole cycle. The data bus is captured in the last clock that the select is high.
- R6: A write releases the bus in this order. In clock HOLD_CYC+2 the select is off while data and address are still driven. In clock HOLD_CYC+3 the data drive is off while the address is still driven. In clock HOLD_CYC+4 the address drive is off.
- R7: A read releases the select in clock HOLD_CYC+2 and the address drive in clock HOLD_CYC+3.
- R8: `rsp_done` is high for exactly one clock, in the address-release clock. `rsp_rdata` carries the captured read data during that clock, reads zero for a write, and is zero whenever `rsp_done` is low.
- R9: A chip index of NUM_CHIPS or more asserts no select and returns zero read data. Its cycle timing is unchanged.
- R10: `mem_addr` holds steady while `mem_addr_en` is 1 and is zero while it is 0. `mem_rw` is 0 only while a write drives the address lines, and is 1 at all other times.
- R11: After reset, `req_ready` is 1, and `mem_cs`, `mem_addr_en`, `mem_data_oe` and `rsp_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Flat address: chip index on top, offset below |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-clock end-of-cycle pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done |
| mem_addr | output | ADDR_W-CHIP_IDX_W | On-chip address lines |
| mem_addr_en | output | 1 | Address lines driven |
| mem_rw | output | 1 | 1 = read, 0 = write |
| mem_cs | output | NUM_CHIPS | One-hot active-high chip selects |
| mem_data | inout | DATA_W | Shared tri-state data bus |
| mem_data_oe | output | 1 | Sequencer drives mem_data |

## Verification
If the phase register entered the wrong state, the drive-enables, the select and `mem_rw` would show the wrong combination within one clock. That shows up as a select before set-up, a data drive during a read, or a wrong release order. A hold counter loaded with the wrong value changes the select width and moves `rsp_done` by the same number of clocks. So every transaction checks the bus signals clock by clock against a timeline computed from HOLD_CYC. A wrongly captured read word, or a wrongly split address, appears at `rsp_rdata` in that transaction's done clock when it is compared with the bench's own memory image.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_SELECT,
    PH_CS_OFF,
    PH_DATA_OFF,
    PH_ADDR_OFF
  } phase_t;
endpackage

// File: rtl/sram_addr_split.sv
module sram_addr_split #(
  parameter int ADDR_W     = 10,
  parameter int CHIP_IDX_W = 2,
  parameter int NUM_CHIPS  = 3,
  localparam int OFS_W     = ADDR_W - CHIP_IDX_W
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [OFS_W-1:0]     offset,
  output logic [NUM_CHIPS-1:0] sel,
  output logic                 hit
);
  logic [CHIP_IDX_W-1:0] idx;

  assign idx    = addr[ADDR_W-1 -: CHIP_IDX_W];
  assign offset = addr[OFS_W-1:0];
  assign hit    = (32'(idx) < NUM_CHIPS);

  for (genvar g = 0; g < NUM_CHIPS; g++) begin : g_sel
    assign sel[g] = (idx == CHIP_IDX_W'(g));
  end

  always_comb begin
    assert_sel_onehot_R1: assert ($onehot0(sel));
  end
endmodule

// File: rtl/sram_hold_timer.sv
module sram_hold_timer #(
  parameter int HOLD_CYC = 3,
  localparam int CW      = $clog2(HOLD_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (start)            cnt <= CW'(HOLD_CYC - 1);
    else if (run && cnt != 0)  cnt <= cnt - 1'b1;
  end

  assign last = run && (cnt == '0);

  assert_last_only_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> run);
endmodule

// File: rtl/sram_phase_fsm.sv
module sram_phase_fsm
  import sram_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic wr,
  input  logic hold_last,
  output logic ready,
  output logic timer_start,
  output logic timer_run,
  output logic addr_en,
  output logic cs_on,
  output logic data_on,
  output logic capture,
  output logic done
);
  phase_t ph, ph_nx;

  always_comb begin
    ph_nx = ph;
    unique case (ph)
      PH_IDLE:     if (accept) ph_nx = PH_SETUP;
      PH_SETUP:    ph_nx = PH_SELECT;
      PH_SELECT:   if (hold_last) ph_nx = PH_CS_OFF;
      PH_CS_OFF:   ph_nx = wr ? PH_DATA_OFF : PH_ADDR_OFF;
      PH_DATA_OFF: ph_nx = PH_ADDR_OFF;
      PH_ADDR_OFF: ph_nx = PH_IDLE;
      default:     ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_IDLE;
    else        ph <= ph_nx;
  end

  assign ready       = (ph == PH_IDLE);
  assign timer_start = (ph == PH_SETUP);
  assign timer_run   = (ph == PH_SELECT);
  assign cs_on       = (ph == PH_SELECT);
  assign addr_en     = (ph == PH_SETUP) || (ph == PH_SELECT) ||
                       (ph == PH_CS_OFF) || (ph == PH_DATA_OFF);
  assign data_on     = wr && ((ph == PH_SETUP) || (ph == PH_SELECT) || (ph == PH_CS_OFF));
  assign capture     = (ph == PH_SELECT) && hold_last && !wr;
  assign done        = (ph == PH_ADDR_OFF);

  assert_ready_only_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!addr_en && !cs_on && !data_on));
  assert_cs_after_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_on) |-> $past(addr_en));
  assert_wr_cs_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_on) && wr) |-> (data_on && addr_en));
  assert_data_before_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_on) |-> addr_en);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/sram_bus_seq.sv
module sram_bus_seq #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int CHIP_IDX_W = 2,
  parameter int NUM_CHIPS  = 3,
  parameter int HOLD_CYC   = 3,
  localparam int OFS_W     = ADDR_W - CHIP_IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_done,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic [OFS_W-1:0]     mem_addr,
  output logic                 mem_addr_en,
  output logic                 mem_rw,
  output logic [NUM_CHIPS-1:0] mem_cs,
  inout  wire  [DATA_W-1:0]    mem_data,
  output logic                 mem_data_oe
);
  logic                 accept;
  logic [OFS_W-1:0]     ofs_in, ofs_q;
  logic [NUM_CHIPS-1:0] sel_in, sel_q;
  logic                 hit_in, hit_q;
  logic                 wr_q;
  logic [DATA_W-1:0]    wdata_q, rdata_q;
  logic                 t_start, t_run, t_last;
  logic                 addr_en, cs_on, data_on, capture, done;

  sram_addr_split #(
    .ADDR_W(ADDR_W), .CHIP_IDX_W(CHIP_IDX_W), .NUM_CHIPS(NUM_CHIPS)
  ) split_i (
    .addr(req_addr), .offset(ofs_in), .sel(sel_in), .hit(hit_in)
  );

  sram_hold_timer #(.HOLD_CYC(HOLD_CYC)) timer_i (
    .clk(clk), .rst_n(rst_n), .start(t_start), .run(t_run), .last(t_last)
  );

  sram_phase_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .wr(wr_q), .hold_last(t_last),
    .ready(req_ready), .timer_start(t_start), .timer_run(t_run),
    .addr_en(addr_en), .cs_on(cs_on), .data_on(data_on),
    .capture(capture), .done(done)
  );

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q   <= '0;
      sel_q   <= '0;
      hit_q   <= 1'b0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else if (accept) begin
      ofs_q   <= ofs_in;
      sel_q   <= sel_in;
      hit_q   <= hit_in;
      wr_q    <= req_write;
      wdata_q <= req_wdata;
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= hit_q ? mem_data : '0;
    end
  end

  assign mem_addr_en = addr_en;
  assign mem_addr    = addr_en ? ofs_q : '0;
  assign mem_rw      = !(wr_q && addr_en);
  assign mem_cs      = cs_on ? sel_q : '0;
  assign mem_data_oe = data_on;
  assign mem_data    = data_on ? wdata_q : 'z;
  assign rsp_done    = done;
  assign rsp_rdata   = done ? rdata_q : '0;

  assert_cs_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_cs));
  assert_cs_needs_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_cs) |-> mem_addr_en);
  assert_write_data_under_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|mem_cs) && !mem_rw) |-> mem_data_oe);
  assert_read_floats_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rw |-> !mem_data_oe);
  assert_addr_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr_en && $past(mem_addr_en)) |-> $stable(mem_addr));
  assert_miss_no_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_q && !req_ready) |-> (mem_cs == '0));
endmodule

// File: tb/sram_bus_seq_tb_top.sv
module sram_bus_seq_tb_top;
  localparam int ADDR_W = 10, DATA_W = 8, CHIP_IDX_W = 2, NUM_CHIPS = 3, H = 3;
  localparam int OFS_W = ADDR_W - CHIP_IDX_W;
  localparam int DEPTH = 1 << OFS_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_done, mem_addr_en, mem_rw, mem_data_oe;
  logic [DATA_W-1:0] rsp_rdata;
  logic [OFS_W-1:0] mem_addr;
  logic [NUM_CHIPS-1:0] mem_cs;
  wire  [DATA_W-1:0] mem_data;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sram_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHIP_IDX_W(CHIP_IDX_W),
                 .NUM_CHIPS(NUM_CHIPS), .HOLD_CYC(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_addr_en(mem_addr_en), .mem_rw(mem_rw), .mem_cs(mem_cs),
    .mem_data(mem_data), .mem_data_oe(mem_data_oe));

  function automatic logic [DATA_W-1:0] init_val(int c, int a);
    return DATA_W'(c * 61 + a * 7 + 3);
  endfunction

  // chip model and bench reference image
  logic [DATA_W-1:0] model [NUM_CHIPS][DEPTH];
  logic [DATA_W-1:0] ref_mem [NUM_CHIPS][DEPTH];
  int cs_idx;

  always_comb begin
    cs_idx = 0;
    for (int i = 0; i < NUM_CHIPS; i++) if (mem_cs[i]) cs_idx = i;
  end

  assign mem_data = ((|mem_cs) && mem_rw) ? model[cs_idx][mem_addr] : 'z;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CHIPS; c++)
        for (int a = 0; a < DEPTH; a++) model[c][a] <= init_val(c, a);
    end else if ((|mem_cs) && !mem_rw) begin
      model[cs_idx][mem_addr] <= mem_data;
    end
  end

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run_txn(bit wr, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] wd, bit hold_busy);
    int idx, last;
    logic [OFS_W-1:0] off;
    bit hit;
    logic [DATA_W-1:0] exp_rd;
    idx  = int'(a[ADDR_W-1 -: CHIP_IDX_W]);
    off  = a[OFS_W-1:0];
    hit  = idx < NUM_CHIPS;
    last = wr ? H + 4 : H + 3;
    exp_rd = (!wr && hit) ? ref_mem[idx][off] : '0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R2", "ready before request", longint'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    @(posedge clk);
    for (int c = 1; c <= last; c++) begin
      logic [NUM_CHIPS-1:0] e_cs;
      bit e_aen, e_doe, e_rw, e_done;
      logic [OFS_W-1:0] e_ad;
      logic [DATA_W-1:0] e_rd;
      string tag;
      @(negedge clk);
      if (c == 1) begin
        if (hold_busy) begin req_addr = ~a; req_write = !wr; req_wdata = ~wd; end
        else req_valid = 1'b0;
      end
      e_cs   = (c >= 2 && c <= H + 1 && hit) ? NUM_CHIPS'(1 << idx) : '0;
      e_aen  = c < last;
      e_doe  = wr && c <= H + 2;
      e_rw   = !(wr && c < last);
      e_ad   = e_aen ? off : '0;
      e_done = c == last;
      e_rd   = e_done ? exp_rd : '0;
      if (!hit) tag = "R9";
      else if (c == 1) tag = "R3";
      else if (c <= H + 1) tag = "R4/R1";
      else if (c == last) tag = "R8";
      else tag = wr ? "R6" : "R7";
      chk({mem_cs, mem_addr_en, mem_data_oe, mem_rw, mem_addr, rsp_done, rsp_rdata, req_ready}
          === {e_cs, e_aen, e_doe, e_rw, e_ad, e_done, e_rd, 1'b0}, tag,
          $sformatf("%s clk%0d {cs,aen,oe,rw,addr,done,rdata,rdy}", wr ? "wr" : "rd", c),
          longint'({mem_cs, mem_addr_en, mem_data_oe, mem_rw, mem_addr, rsp_done, rsp_rdata, req_ready}),
          longint'({e_cs, e_aen, e_doe, e_rw, e_ad, e_done, e_rd, 1'b0}));
      if (e_doe)
        chk(mem_data === wd, "R3", "write data on bus", longint'(mem_data), longint'(wd));
      if (!wr)
        chk(mem_data_oe == 1'b0, "R5", "read leaves bus floating", longint'(mem_data_oe), 0);
      if (c == last) req_valid = 1'b0;
    end
    if (wr && hit) ref_mem[idx][off] = wd;
    if (hold_busy) begin
      @(negedge clk);
      chk(mem_addr_en == 1'b0 && mem_cs == '0 && req_ready, "R2",
          "held request ignored after cycle", longint'({mem_addr_en, req_ready}), 1);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NUM_CHIPS; c++)
      for (int a = 0; a < DEPTH; a++) ref_mem[c][a] = init_val(c, a);
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({req_ready, mem_cs, mem_addr_en, mem_data_oe, rsp_done} === {1'b1, {NUM_CHIPS{1'b0}}, 3'b000},
        "R11", "reset outputs", longint'({req_ready, mem_cs, mem_addr_en, mem_data_oe, rsp_done}),
        longint'({1'b1, {NUM_CHIPS{1'b0}}, 3'b000}));
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_rw == 1'b1 && mem_addr == '0, "R10", "idle rw high, addr zero",
        longint'({mem_rw, mem_addr}), longint'({1'b1, {OFS_W{1'b0}}}));
    // directed corners
    run_txn(1'b1, {2'd0, 8'h12}, 8'hA5, 1'b0);
    run_txn(1'b0, {2'd0, 8'h12}, 8'h00, 1'b0);
    run_txn(1'b1, {2'd2, 8'hFF}, 8'h3C, 1'b1);
    run_txn(1'b0, {2'd2, 8'hFF}, 8'h00, 1'b1);
    run_txn(1'b0, {2'd1, 8'h00}, 8'h00, 1'b0);
    run_txn(1'b0, {2'd3, 8'h40}, 8'h00, 1'b0);
    run_txn(1'b1, {2'd3, 8'h40}, 8'h77, 1'b0);
    // constrained random mix
    for (int i = 0; i < 80; i++) begin
      logic [ADDR_W-1:0] ra;
      ra = ADDR_W'($urandom);
      if (($urandom % 4) != 0) ra[7:4] = 4'h0;
      run_txn(1'($urandom), ra, DATA_W'($urandom), 1'($urandom));
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule